// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Bank

This block collects interrupt events from one peripheral function with up to `N_SRC` level inputs and presents them to two independent host interrupt lines. Each input is synchronised, then checked for a rising and/or falling edge according to its own two-bit trigger field. A qualifying edge sets that input's bit in the status register of both lines. Each line has its own mask register and its own active-low interrupt output.

Software reaches the bank through a byte-wide register port. This port reads and writes the two status registers, the two mask registers, the packed trigger-select register, a control register and a test register that forces status bits. The control register chooses the clearing style. In clear-on-read mode, reading a status byte clears it. In clear-on-write mode, software writes ones to the bits it wants cleared. The control register also decides whether a second event on an input that is already pending is held and replayed after the clear.

Top module: `sih_bank`

## Requirements
- R1: After reset, every status bit reads 0, every valid mask bit reads 1 (padding bits above `N_SRC` read 0), every trigger field reads 00, the control register reads 0x01 and both `irq_n` outputs are high.
- R2: Byte addresses with NB=ceil(N_SRC/8) and NE=ceil(2*N_SRC/8) are:
  - line-0 status at 0 to NB-1
  - line-0 mask at NB to 2NB-1
  - line-1 status at 2NB to 3NB-1
  - line-1 mask at 3NB to 4NB-1
  - trigger select at 4NB to 4NB+NE-1
  - control at 4NB+NE
  - test set at 4NB+NE+1 to 4NB+NE+NB, which reads as 0
  - any unmapped address reads 0
- R3: Input i's trigger field sits in trigger byte i/4 at bits 2*(i mod 4)+1:2*(i mod 4). In that field, bit 0 enables falling-edge detection, bit 1 enables rising-edge detection, and 11 detects both edges.
- R4: An input whose trigger field is 00 never sets a status bit.
- R5: A qualifying edge sets the input's status bit in both lines. A change on `irq_src` driven after clock edge 0 becomes visible in status and `irq_n` after clock edge 3 and not before.
- R6: `irq_n[l]` is low exactly when line l has a status bit set whose mask bit is 0. A mask bit of 1 blocks only that line.
- R7: With control bit 0 (clear-on-read) set, a read of a status byte returns its bits and clears them in that line only. Writes to status bytes are ignored.
- R8: With control bit 0 clear, a write to a status byte clears the bits written as 1 in that line only. Reads do not clear.
- R9: With control bit 1 (pending-disable) clear, an edge that arrives while the status bit is already set is held. The first clear then leaves the bit set, and a second clear removes it. With control bit 1 set, one clear is enough.
- R10: Writing ones to a test-set byte sets the matching status bits in both lines. Bits above `N_SRC` are dropped.
- R11: An edge that qualifies in the same cycle as a clear of that bit leaves the bit set.
- R12: Multi-byte status, mask and test-set registers are little-endian: input 8k+j is byte k, bit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Asynchronous level inputs from the peripheral |
| reg_addr | input | AW | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears status in clear-on-read mode |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_n | output | 2 | Active-low interrupt, one per host line |

## Verification
A corrupted status, buffer or mask bit shows up at the ports in one of two ways. It may show on `irq_n` in the cycle after the faulty register edge. Otherwise it shows on the next status or mask read, because every register can be read back. A bad synchroniser depth or edge polarity shifts the `irq_n` assertion by a cycle, or makes a status bit appear for the wrong trigger field. The sweep over every input and trigger code exposes this within three cycles of the stimulus. A faulty hold buffer or clear priority is caught because a bit that stays set, or vanishes, after exactly one clear is read back immediately.

// File: rtl/sih_pkg.sv
package sih_pkg;

    localparam int LINES = 2;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_t;

    typedef struct packed {
        logic [5:0] spare;
        logic       pend_dis;
        logic       clr_on_read;
    } sih_ctrl_t;

    localparam sih_ctrl_t CTRL_RESET = '{spare: 6'd0, pend_dis: 1'b0, clr_on_read: 1'b1};

    function automatic int bytes_for_bits(int bits);
        return (bits + 7) / 8;
    endfunction

endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect
    import sih_pkg::*;
#(
    parameter int N_SRC = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SRC-1:0]     src,
    input  logic [2*N_SRC-1:0]   trig,
    output logic [N_SRC-1:0]     evt
);

    logic [N_SRC-1:0] meta_q;
    logic [N_SRC-1:0] sync_q;
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        trig_t mode;
        logic  rise_en;
        logic  fall_en;
        assign mode    = trig_t'(trig[2*gi +: 2]);
        assign rise_en = (mode == TRIG_RISE) || (mode == TRIG_BOTH);
        assign fall_en = (mode == TRIG_FALL) || (mode == TRIG_BOTH);
        assign evt[gi] = (rise_en & sync_q[gi] & ~prev_q[gi]) |
                         (fall_en & ~sync_q[gi] & prev_q[gi]);
    end

endmodule

// File: rtl/sih_line.sv
module sih_line #(
    parameter int N_SRC = 18,
    parameter int NB    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    input  logic             pend_dis,
    input  logic [NB-1:0]    mask_wen,
    input  logic [7:0]       mask_wdata,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] mask,
    output logic             irq_n
);

    logic [N_SRC-1:0] status_q, status_d;
    logic [N_SRC-1:0] hold_q, hold_d;
    logic [N_SRC-1:0] mask_q;

    always_comb begin
        // a held event re-arms the bit at the moment it is cleared
        status_d = (status_q & ~clr_vec) | evt | set_vec | (clr_vec & hold_q);
        hold_d   = (hold_q & ~clr_vec) |
                   (evt & status_q & ~clr_vec & {N_SRC{~pend_dis}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            hold_q   <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= status_d;
            hold_q   <= hold_d;
            for (int k = 0; k < N_SRC; k++) begin
                if (mask_wen[k/8]) mask_q[k] <= mask_wdata[k%8];
            end
        end
    end

    assign status = status_q;
    assign mask   = mask_q;
    assign irq_n  = ~|(status_q & ~mask_q);

    // a status bit only drops in a cycle that carried a clear for it
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_vec)) == '0));

    // a status bit only rises from an edge, a test set or a held event
    assert_status_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((status_q & ~$past(status_q)) & ~($past(evt) | $past(set_vec))) == '0));

    // holding a second event requires pending-disable to be clear
    assert_hold_gated_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((hold_q & ~$past(hold_q)) == '0) || !$past(pend_dis)));

    // an edge coinciding with a clear leaves the bit set
    assert_edge_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(evt) & $past(clr_vec)) & ~status_q) == '0));

endmodule

// File: rtl/sih_bank.sv
module sih_bank
    import sih_pkg::*;
#(
    parameter int N_SRC = 18,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   irq_src,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_rd,
    output logic [7:0]         reg_rdata,
    output logic [LINES-1:0]   irq_n
);

    localparam int NB    = bytes_for_bits(N_SRC);
    localparam int NT    = 2 * N_SRC;
    localparam int NE    = bytes_for_bits(NT);
    localparam int A_EDG = LINES * 2 * NB;
    localparam int A_CTL = A_EDG + NE;
    localparam int A_SET = A_CTL + 1;

    sih_ctrl_t        ctrl_q;
    logic [NT-1:0]    edge_q;
    logic [31:0]      addr_w;

    logic [NB-1:0]    st_hit [LINES];
    logic [NB-1:0]    mk_hit [LINES];
    logic [NB-1:0]    set_hit;
    logic [NE-1:0]    edg_hit;
    logic             ctl_hit;

    logic [N_SRC-1:0] clr_v [LINES];
    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] evt_v;
    logic [N_SRC-1:0] st_v  [LINES];
    logic [N_SRC-1:0] mk_v  [LINES];
    logic [N_SRC-1:0] trig_any;

    logic [NB*8-1:0]  pad_s;
    logic [NB*8-1:0]  pad_m;
    logic [NE*8-1:0]  pad_e;

    assign addr_w = 32'(reg_addr);

    // address decode into per-byte strobes
    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            for (int b = 0; b < NB; b++) begin
                st_hit[l][b] = (addr_w == 32'(2*NB*l + b)) &&
                               (ctrl_q.clr_on_read ? reg_rd : reg_wr);
                mk_hit[l][b] = (addr_w == 32'(2*NB*l + NB + b)) && reg_wr;
            end
        end
        for (int b = 0; b < NB; b++) set_hit[b] = reg_wr && (addr_w == 32'(A_SET + b));
        for (int b = 0; b < NE; b++) edg_hit[b] = reg_wr && (addr_w == 32'(A_EDG + b));
        ctl_hit = reg_wr && (addr_w == 32'(A_CTL));
    end

    // byte strobes spread to per-input clear and set vectors
    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            for (int k = 0; k < N_SRC; k++) begin
                clr_v[l][k] = st_hit[l][k/8] & (ctrl_q.clr_on_read | reg_wdata[k%8]);
            end
        end
        for (int k = 0; k < N_SRC; k++) begin
            set_v[k]    = set_hit[k/8] & reg_wdata[k%8];
            trig_any[k] = edge_q[2*k] | edge_q[2*k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            ctrl_q <= CTRL_RESET;
        end else begin
            for (int k = 0; k < NT; k++) begin
                if (edg_hit[k/8]) edge_q[k] <= reg_wdata[k%8];
            end
            if (ctl_hit) begin
                ctrl_q <= '{spare: 6'd0, pend_dis: reg_wdata[1], clr_on_read: reg_wdata[0]};
            end
        end
    end

    sih_edge_detect #(.N_SRC(N_SRC)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .src  (irq_src),
        .trig (edge_q),
        .evt  (evt_v)
    );

    for (genvar gl = 0; gl < LINES; gl++) begin : g_line
        sih_line #(.N_SRC(N_SRC), .NB(NB)) u_line (
            .clk        (clk),
            .rst        (rst),
            .evt        (evt_v),
            .set_vec    (set_v),
            .clr_vec    (clr_v[gl]),
            .pend_dis   (ctrl_q.pend_dis),
            .mask_wen   (mk_hit[gl]),
            .mask_wdata (reg_wdata),
            .status     (st_v[gl]),
            .mask       (mk_v[gl]),
            .irq_n      (irq_n[gl])
        );

        assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (rst)
            !irq_n[gl] |-> (|st_v[gl]));
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        pad_e = '0;
        pad_e[NT-1:0] = edge_q;
        pad_s = '0;
        pad_m = '0;
        for (int l = 0; l < LINES; l++) begin
            pad_s = '0;
            pad_m = '0;
            pad_s[N_SRC-1:0] = st_v[l];
            pad_m[N_SRC-1:0] = mk_v[l];
            for (int b = 0; b < NB; b++) begin
                if (addr_w == 32'(2*NB*l + b))      reg_rdata = pad_s[8*b +: 8];
                if (addr_w == 32'(2*NB*l + NB + b)) reg_rdata = pad_m[8*b +: 8];
            end
        end
        for (int b = 0; b < NE; b++) begin
            if (addr_w == 32'(A_EDG + b)) reg_rdata = pad_e[8*b +: 8];
        end
        if (addr_w == 32'(A_CTL)) reg_rdata = ctrl_q;
    end

    // an input with trigger field 00 never produces an event
    assert_trig_off_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_v & ~trig_any) == '0);

endmodule

// File: tb/sih_bank_test.sv
module sih_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 18;
    localparam int AW    = 8;
    localparam int NB    = (N + 7) / 8;
    localparam int NE    = (2 * N + 7) / 8;
    localparam int A_ST0 = 0;
    localparam int A_MK0 = NB;
    localparam int A_ST1 = 2 * NB;
    localparam int A_MK1 = 3 * NB;
    localparam int A_EDG = 4 * NB;
    localparam int A_CTL = A_EDG + NE;
    localparam int A_SET = A_CTL + 1;
    localparam int A_END = A_SET + NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_src = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_rdata;
    logic [1:0]    irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sih_bank #(.N_SRC(N), .AW(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_reg(int a, int d);
        reg_addr  = AW'(a);
        reg_wdata = 8'(d);
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(int a, output int d);
        reg_addr = AW'(a);
        reg_rd   = 1'b1;
        #1;
        d = int'(reg_rdata);
        @(posedge clk);
        #1;
        reg_rd = 1'b0;
    endtask

    function automatic int reset_value(int a);
        int lo;
        lo = N - 8 * (NB - 1);
        if ((a >= A_MK0 && a < A_MK0 + NB) || (a >= A_MK1 && a < A_MK1 + NB)) begin
            int b;
            b = (a >= A_MK1) ? a - A_MK1 : a - A_MK0;
            return (b == NB - 1) ? ((1 << lo) - 1) : 8'hFF;
        end
        if (a == A_CTL) return 1;
        return 0;
    endfunction

    initial begin
        int d;
        int byte_i;
        int bit_i;
        rst = 1'b1;
        tick(3);
        check("R1 irq_n in reset", int'(irq_n), 3);
        rst = 1'b0;
        tick(1);

        // R1 and R2: every address holds its reset value
        for (int a = 0; a <= A_END + 1; a++) begin
            rd_reg(a, d);
            check($sformatf("R1/R2 reset read addr %0d", a), d, reset_value(a));
        end

        // open line 0, keep line 1 masked
        for (int b = 0; b < NB; b++) wr_reg(A_MK0 + b, 0);

        // sweep every input over every trigger code (R3, R4, R12)
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                byte_i = i / 8;
                bit_i  = i % 8;
                wr_reg(A_EDG + i / 4, m << (2 * (i % 4)));
                irq_src[i] = 1'b1;
                tick(3);
                check($sformatf("R6 irq_n line0 rise i=%0d m=%0d", i, m), int'(irq_n[0]), (m >> 1) ? 0 : 1);
                check($sformatf("R6 irq_n line1 masked i=%0d", i), int'(irq_n[1]), 1);
                rd_reg(A_ST0 + byte_i, d);
                check($sformatf("R3/R12 rise line0 i=%0d m=%0d", i, m), d, ((m >> 1) & 1) << bit_i);
                rd_reg(A_ST1 + byte_i, d);
                check($sformatf("R5 rise line1 i=%0d m=%0d", i, m), d, ((m >> 1) & 1) << bit_i);
                irq_src[i] = 1'b0;
                tick(3);
                rd_reg(A_ST0 + byte_i, d);
                check($sformatf("R3/R4 fall line0 i=%0d m=%0d", i, m), d, (m & 1) << bit_i);
                rd_reg(A_ST1 + byte_i, d);
                check($sformatf("R5 fall line1 i=%0d m=%0d", i, m), d, (m & 1) << bit_i);
            end
            wr_reg(A_EDG + i / 4, 0);
        end

        // R5 latency and R6 per-line masking, input 5 rising
        wr_reg(A_EDG + 1, 8'h08);
        irq_src[5] = 1'b1;
        tick(2);
        check("R5 not yet visible after edge 2", int'(irq_n), 3);
        tick(1);
        check("R5 visible after edge 3", int'(irq_n), 2);
        wr_reg(A_MK1 + 0, 8'hDF);
        check("R6 unmask line1", int'(irq_n), 0);
        wr_reg(A_MK0 + 0, 8'h20);
        check("R6 mask line0 only", int'(irq_n), 1);
        // R7: writes to status ignored in clear-on-read mode
        wr_reg(A_ST0 + 0, 8'hFF);
        rd_reg(A_ST0 + 0, d);
        check("R7 write ignored, read returns bit", d, 8'h20);
        rd_reg(A_ST0 + 0, d);
        check("R7 cleared by read", d, 0);
        check("R7 line1 still pending", int'(irq_n), 1);
        rd_reg(A_ST1 + 0, d);
        check("R7 line1 read", d, 8'h20);
        check("R7 both lines idle", int'(irq_n), 3);
        wr_reg(A_MK0 + 0, 0);
        wr_reg(A_MK1 + 0, 8'hFF);
        irq_src[5] = 1'b0;
        tick(3);
        wr_reg(A_EDG + 1, 0);

        // R8 clear-on-write, input 9 rising
        wr_reg(A_CTL, 0);
        rd_reg(A_CTL, d);
        check("R8 control readback", d, 0);
        wr_reg(A_EDG + 2, 8'h08);
        irq_src[9] = 1'b1;
        tick(3);
        rd_reg(A_ST0 + 1, d);
        check("R8 first read", d, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R8 read does not clear", d, 8'h02);
        wr_reg(A_ST0 + 1, 8'h01);
        rd_reg(A_ST0 + 1, d);
        check("R8 zero bit leaves status", d, 8'h02);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R8 one bit clears", d, 0);
        rd_reg(A_ST1 + 1, d);
        check("R8 other line untouched", d, 8'h02);
        wr_reg(A_ST1 + 1, 8'hFF);
        rd_reg(A_ST1 + 1, d);
        check("R8 line1 cleared", d, 0);

        // R9 with hold enabled: two edges before a clear need two clears
        wr_reg(A_EDG + 2, 8'h0C);
        irq_src[9] = 1'b0;
        tick(3);
        irq_src[9] = 1'b1;
        tick(3);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R9 held event re-sets after first clear", d, 8'h02);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R9 second clear empties", d, 0);
        wr_reg(A_ST1 + 1, 8'h02);
        wr_reg(A_ST1 + 1, 8'h02);
        rd_reg(A_ST1 + 1, d);
        check("R9 line1 two clears", d, 0);

        // R9 with pending-disable set: one clear is enough
        wr_reg(A_CTL, 8'h02);
        irq_src[9] = 1'b0;
        tick(3);
        irq_src[9] = 1'b1;
        tick(3);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R9 pending-disable single clear", d, 0);
        wr_reg(A_ST1 + 1, 8'hFF);

        // R11: edge arrives in the very cycle its bit is cleared
        irq_src[9] = 1'b0;
        tick(3);
        rd_reg(A_ST0 + 1, d);
        check("R11 precondition set", d, 8'h02);
        irq_src[9] = 1'b1;
        tick(2);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R11 edge wins over clear", d, 8'h02);
        wr_reg(A_ST0 + 1, 8'h02);
        rd_reg(A_ST0 + 1, d);
        check("R11 later clear empties", d, 0);
        wr_reg(A_ST1 + 1, 8'hFF);
        wr_reg(A_EDG + 2, 0);

        // R10 test set register, back in clear-on-read
        wr_reg(A_CTL, 8'h01);
        wr_reg(A_SET + 2, 8'hFF);
        rd_reg(A_ST0 + 2, d);
        check("R10 set top byte line0", d, 8'h03);
        rd_reg(A_ST1 + 2, d);
        check("R10 set top byte line1", d, 8'h03);
        rd_reg(A_SET + 2, d);
        check("R2 set register reads zero", d, 0);
        wr_reg(A_SET + 0, 8'h81);
        rd_reg(A_ST0 + 0, d);
        check("R10/R12 set byte0 line0", d, 8'h81);
        rd_reg(A_ST1 + 0, d);
        check("R10/R12 set byte0 line1", d, 8'h81);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule